// File: doc/BRIEF.md
# Integer ALU with Overflow Traps

A purely combinational 32-bit integer execution unit for a scalar pipeline. Each cycle it receives an 8-bit operation code, two register operands (`src_a` is the first source register, `src_b` the second), a 16-bit immediate and a 5-bit constant shift count. It returns a 32-bit result, a flag saying the result may be written back, and a flag raising a signed-overflow trap.

The unit covers wrapping and trapping addition and subtraction, bitwise logic, constant and variable shifts in logical and arithmetic flavours, signed and unsigned set-less-than, and load-upper-immediate, each in register and immediate forms where they exist. A trapping operation that overflows withholds its result so the destination register keeps its old value. Opcodes outside the supported set produce no result and no trap, so a neighbouring unit can own them.

Top module: `alu_exec_unit`

## Requirements
- R1: Addition and subtraction wrap modulo 2^32: 0x40 gives src_a+src_b, 0x42 gives src_a+src_b, 0x41 and 0x43 give src_a plus the sign-extended immediate, 0x44 and 0x45 give src_a-src_b; `result_ok` is 1 when no trap is raised.
- R2: Opcodes 0x40 and 0x41 raise `ovf_trap` when both addends share a sign and the sum's bit 31 differs from it; on a trap `result_ok` is 0.
- R3: Opcode 0x44 raises `ovf_trap` when the signed difference src_a-src_b does not fit in 32 bits; on a trap `result_ok` is 0.
- R4: Opcodes 0x42, 0x43 and 0x45 never raise `ovf_trap`, whatever the operands.
- R5: Register logic ops: 0x4e AND, 0x50 OR, 0x52 XOR, 0x54 NOR of src_a and src_b.
- R6: Immediate logic ops 0x4f AND, 0x51 OR, 0x53 XOR use the zero-extended immediate; the upper 16 bits of src_a pass through OR/XOR and are cleared by AND.
- R7: Constant shifts shift src_b by `shamt`: 0x55 left and 0x57 right, both filling vacated bits with zeros.
- R8: Arithmetic right shifts (0x59 by `shamt`, 0x5a by src_a) fill vacated upper bits with a copy of src_b bit 31.
- R9: Variable shifts 0x56 (left), 0x58 (logical right) and 0x5a use only src_a bits 4..0 as the count; `shamt` has no effect on them.
- R10: Set-less-than ops give exactly 1 or 0: 0x5b signed src_a<src_b, 0x5d unsigned src_a<src_b, 0x5c signed src_a<sign-extended immediate, 0x5e unsigned src_a<sign-extended immediate taken as unsigned.
- R11: Opcode 0xa2 returns the immediate in bits 31..16 with bits 15..0 zero.
- R12: Any other opcode gives `result` 0, `result_ok` 0 and `ovf_trap` 0.
- R13: Only opcodes 0x40, 0x41 and 0x44 can ever raise `ovf_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 8 | Operation code |
| src_a | input | 32 | First source register operand (also variable shift count) |
| src_b | input | 32 | Second source register operand (shift data) |
| imm16 | input | 16 | Instruction immediate field |
| shamt | input | 5 | Constant shift count |
| result | output | 32 | Operation result |
| result_ok | output | 1 | Result may be written to the destination |
| ovf_trap | output | 1 | Signed overflow trap |

## Verification
The hardest situations to reach are the exact overflow boundaries: uniformly random operands rarely land on sums that cross 0x7fffffff or differences that cross 0x80000000 by one, and rarely produce a sign-extended immediate of 0x8000 or above paired with a small unsigned comparison. The stimulus draws operands from a pool weighted toward 0, 1, all-ones and the two signed extremes, mixes in fully random words, and adds directed vectors at each boundary; the variable-shift cases put garbage in src_a bits 31..5 and in `shamt` so only the low five count bits can explain the output.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OPW = 8;

  typedef enum logic [OPW-1:0] {
    OP_ADD_T   = 8'h40,
    OP_ADDI_T  = 8'h41,
    OP_ADD_W   = 8'h42,
    OP_ADDI_W  = 8'h43,
    OP_SUB_T   = 8'h44,
    OP_SUB_W   = 8'h45,
    OP_AND_R   = 8'h4e,
    OP_AND_I   = 8'h4f,
    OP_OR_R    = 8'h50,
    OP_OR_I    = 8'h51,
    OP_XOR_R   = 8'h52,
    OP_XOR_I   = 8'h53,
    OP_NOR_R   = 8'h54,
    OP_SHL_K   = 8'h55,
    OP_SHL_V   = 8'h56,
    OP_SHR_K   = 8'h57,
    OP_SHR_V   = 8'h58,
    OP_SAR_K   = 8'h59,
    OP_SAR_V   = 8'h5a,
    OP_LT_S_R  = 8'h5b,
    OP_LT_S_I  = 8'h5c,
    OP_LT_U_R  = 8'h5d,
    OP_LT_U_I  = 8'h5e,
    OP_UPPER   = 8'ha2
  } alu_op_e;

  typedef enum logic [2:0] {
    SRC_SUM,
    SRC_LOGIC,
    SRC_SHIFT,
    SRC_LESS,
    SRC_UPPER,
    SRC_NONE
  } res_src_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_NOR
  } logic_fn_e;

  typedef struct packed {
    res_src_e  src;
    logic_fn_e lfn;
    logic      use_imm;
    logic      imm_zext;
    logic      do_sub;
    logic      may_trap;
    logic      sh_left;
    logic      sh_arith;
    logic      sh_var;
    logic      lt_signed;
  } alu_ctl_t;

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] imm_sext,
  output logic [DATA_W-1:0] imm_zext,
  output logic [DATA_W-1:0] imm_upper
);
  localparam int PAD_W = DATA_W - IMM_W;

  assign imm_sext  = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign imm_zext  = {{PAD_W{1'b0}}, imm};
  assign imm_upper = {imm, {PAD_W{1'b0}}};
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);
  logic [DATA_W-1:0] opb_eff;

  // subtraction as a + ~b + 1 keeps a single carry chain
  assign opb_eff = sub ? ~opb : opb;
  assign sum     = opa + opb_eff + {{(DATA_W-1){1'b0}}, sub};

  // overflow: effective addends agree in sign, sum disagrees
  assign ovf = (opa[DATA_W-1] == opb_eff[DATA_W-1]) &&
               (sum[DATA_W-1] != opa[DATA_W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              left,
  input  logic              arith,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;
  logic              fill;

  // left shifts reuse the right-shift network on bit-reversed data
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign rev_in[b]  = din[DATA_W-1-b];
    assign rev_out[b] = stage[SH_W][DATA_W-1-b];
  end

  assign fill     = arith & ~left & din[DATA_W-1];
  assign stage[0] = left ? rev_in : din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    assign stage[s+1] = amt[s] ?
      {{DIST{fill}}, stage[s][DATA_W-1:DIST]} : stage[s];
  end

  assign dout = left ? rev_out : stage[SH_W];
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [OPW-1:0]    op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result,
  output logic              result_ok,
  output logic              ovf_trap
);
  alu_ctl_t          ctl;
  logic [DATA_W-1:0] imm_sext, imm_zext, imm_upper;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] sum_val, logic_val, shift_val;
  logic              sum_ovf;
  logic              less_bit;
  logic [SH_W-1:0]   sh_amt;

  // decode
  always_comb begin
    ctl = '{src: SRC_SUM, lfn: LG_AND, default: 1'b0};
    unique case (op_code)
      OP_ADD_T:  ctl.may_trap = 1'b1;
      OP_ADDI_T: begin ctl.use_imm = 1'b1; ctl.may_trap = 1'b1; end
      OP_ADD_W:  ;
      OP_ADDI_W: ctl.use_imm = 1'b1;
      OP_SUB_T:  begin ctl.do_sub = 1'b1; ctl.may_trap = 1'b1; end
      OP_SUB_W:  ctl.do_sub = 1'b1;
      OP_AND_R:  begin ctl.src = SRC_LOGIC; ctl.lfn = LG_AND; end
      OP_OR_R:   begin ctl.src = SRC_LOGIC; ctl.lfn = LG_OR;  end
      OP_XOR_R:  begin ctl.src = SRC_LOGIC; ctl.lfn = LG_XOR; end
      OP_NOR_R:  begin ctl.src = SRC_LOGIC; ctl.lfn = LG_NOR; end
      OP_AND_I: begin
        ctl.src = SRC_LOGIC; ctl.lfn = LG_AND;
        ctl.use_imm = 1'b1; ctl.imm_zext = 1'b1;
      end
      OP_OR_I: begin
        ctl.src = SRC_LOGIC; ctl.lfn = LG_OR;
        ctl.use_imm = 1'b1; ctl.imm_zext = 1'b1;
      end
      OP_XOR_I: begin
        ctl.src = SRC_LOGIC; ctl.lfn = LG_XOR;
        ctl.use_imm = 1'b1; ctl.imm_zext = 1'b1;
      end
      OP_SHL_K: begin ctl.src = SRC_SHIFT; ctl.sh_left = 1'b1; end
      OP_SHL_V: begin
        ctl.src = SRC_SHIFT; ctl.sh_left = 1'b1; ctl.sh_var = 1'b1;
      end
      OP_SHR_K:  ctl.src = SRC_SHIFT;
      OP_SHR_V:  begin ctl.src = SRC_SHIFT; ctl.sh_var = 1'b1; end
      OP_SAR_K:  begin ctl.src = SRC_SHIFT; ctl.sh_arith = 1'b1; end
      OP_SAR_V: begin
        ctl.src = SRC_SHIFT; ctl.sh_arith = 1'b1; ctl.sh_var = 1'b1;
      end
      OP_LT_S_R: begin ctl.src = SRC_LESS; ctl.lt_signed = 1'b1; end
      OP_LT_S_I: begin
        ctl.src = SRC_LESS; ctl.lt_signed = 1'b1; ctl.use_imm = 1'b1;
      end
      OP_LT_U_R: ctl.src = SRC_LESS;
      OP_LT_U_I: begin ctl.src = SRC_LESS; ctl.use_imm = 1'b1; end
      OP_UPPER:  ctl.src = SRC_UPPER;
      default:   ctl.src = SRC_NONE;
    endcase
  end

  alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
    .imm       (imm16),
    .imm_sext  (imm_sext),
    .imm_zext  (imm_zext),
    .imm_upper (imm_upper)
  );

  assign opb = !ctl.use_imm ? src_b : (ctl.imm_zext ? imm_zext : imm_sext);

  alu_addsub #(.DATA_W(DATA_W)) u_add (
    .opa (src_a),
    .opb (opb),
    .sub (ctl.do_sub),
    .sum (sum_val),
    .ovf (sum_ovf)
  );

  assign sh_amt = ctl.sh_var ? src_a[SH_W-1:0] : shamt;

  alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shf (
    .din   (src_b),
    .amt   (sh_amt),
    .left  (ctl.sh_left),
    .arith (ctl.sh_arith),
    .dout  (shift_val)
  );

  always_comb begin
    unique case (ctl.lfn)
      LG_AND:  logic_val = src_a & opb;
      LG_OR:   logic_val = src_a | opb;
      LG_XOR:  logic_val = src_a ^ opb;
      default: logic_val = ~(src_a | opb);
    endcase
  end

  assign less_bit = ctl.lt_signed ? ($signed(src_a) < $signed(opb))
                                  : (src_a < opb);

  always_comb begin
    unique case (ctl.src)
      SRC_SUM:   result = sum_val;
      SRC_LOGIC: result = logic_val;
      SRC_SHIFT: result = shift_val;
      SRC_LESS:  result = {{(DATA_W-1){1'b0}}, less_bit};
      SRC_UPPER: result = imm_upper;
      default:   result = '0;
    endcase
  end

  assign ovf_trap  = ctl.may_trap & sum_ovf;
  assign result_ok = (ctl.src != SRC_NONE) & ~ovf_trap;
endmodule

// File: rtl/alu_exec_unit_chk.sv
module alu_exec_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = 5
) (
  input logic [7:0]        op_code,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [IMM_W-1:0]  imm16,
  input logic [SH_W-1:0]   shamt,
  input logic [DATA_W-1:0] result,
  input logic              result_ok,
  input logic              ovf_trap
);
  logic is_known;
  assign is_known = (op_code inside {[8'h40:8'h45], [8'h4e:8'h5e], 8'ha2});

  always_comb begin
    p_trap_blocks_write_r2: assert (!(ovf_trap && result_ok))
      else $error("trap with result_ok set");
    p_wrap_never_traps_r4: assert (!(op_code inside {8'h42, 8'h43, 8'h45}) || !ovf_trap)
      else $error("wrapping op trapped");
    p_only_checked_trap_r13: assert (!ovf_trap || (op_code inside {8'h40, 8'h41, 8'h44}))
      else $error("trap on non-trapping opcode");
    p_less_is_bool_r10: assert (!(op_code inside {[8'h5b:8'h5e]}) ||
                                (result[DATA_W-1:1] == '0 && result_ok))
      else $error("set-less-than result not boolean");
    p_upper_form_r11: assert (op_code != 8'ha2 ||
                              (result == {imm16, {(DATA_W-IMM_W){1'b0}}}))
      else $error("load-upper mismatch");
    p_unknown_silent_r12: assert (is_known ||
                                  (result == '0 && !result_ok && !ovf_trap))
      else $error("unknown opcode not silent");
  end
endmodule

bind alu_exec_unit alu_exec_unit_chk #(
  .DATA_W (DATA_W), .IMM_W (IMM_W), .SH_W (SH_W)
) u_chk (
  .op_code   (op_code),
  .src_a     (src_a),
  .src_b     (src_b),
  .imm16     (imm16),
  .shamt     (shamt),
  .result    (result),
  .result_ok (result_ok),
  .ovf_trap  (ovf_trap)
);

// File: tb/alu_exec_unit_test.sv
module alu_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  op_code = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        result_ok, ovf_trap;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  alu_exec_unit uut (
    .op_code (op_code), .src_a (src_a), .src_b (src_b), .imm16 (imm16),
    .shamt (shamt), .result (result), .result_ok (result_ok),
    .ovf_trap (ovf_trap)
  );

  typedef struct packed { logic [31:0] r; logic ok; logic tr; } exp_t;

  function automatic exp_t model(input logic [7:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic [15:0] i,
                                 input logic [4:0] k);
    exp_t e;
    logic signed [32:0] wide;
    logic [31:0] se, ze;
    se = {{16{i[15]}}, i};
    ze = {16'h0, i};
    e.ok = 1'b1; e.tr = 1'b0; e.r = '0;
    case (op)
      8'h40, 8'h42: begin
        wide = $signed({a[31], a}) + $signed({b[31], b});
        e.r = wide[31:0];
        if (op == 8'h40) e.tr = (wide[32] != wide[31]);
      end
      8'h41, 8'h43: begin
        wide = $signed({a[31], a}) + $signed({se[31], se});
        e.r = wide[31:0];
        if (op == 8'h41) e.tr = (wide[32] != wide[31]);
      end
      8'h44, 8'h45: begin
        wide = $signed({a[31], a}) - $signed({b[31], b});
        e.r = wide[31:0];
        if (op == 8'h44) e.tr = (wide[32] != wide[31]);
      end
      8'h4e: e.r = a & b;
      8'h4f: e.r = a & ze;
      8'h50: e.r = a | b;
      8'h51: e.r = a | ze;
      8'h52: e.r = a ^ b;
      8'h53: e.r = a ^ ze;
      8'h54: e.r = ~(a | b);
      8'h55: e.r = b << k;
      8'h56: e.r = b << a[4:0];
      8'h57: e.r = b >> k;
      8'h58: e.r = b >> a[4:0];
      8'h59: e.r = 32'($signed(b) >>> k);
      8'h5a: e.r = 32'($signed(b) >>> a[4:0]);
      8'h5b: e.r = {31'h0, $signed(a) < $signed(b)};
      8'h5c: e.r = {31'h0, $signed(a) < $signed(se)};
      8'h5d: e.r = {31'h0, a < b};
      8'h5e: e.r = {31'h0, a < se};
      8'ha2: e.r = {i, 16'h0};
      default: e.ok = 1'b0;
    endcase
    if (e.tr) e.ok = 1'b0;
    return e;
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h40, 8'h41: return "R2";
      8'h44: return "R3";
      8'h42, 8'h43, 8'h45: return "R4";
      8'h4e, 8'h50, 8'h52, 8'h54: return "R5";
      8'h4f, 8'h51, 8'h53: return "R6";
      8'h55, 8'h57: return "R7";
      8'h59, 8'h5a: return "R8";
      8'h56, 8'h58: return "R9";
      8'h5b, 8'h5c, 8'h5d, 8'h5e: return "R10";
      8'ha2: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [7:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i,
                       input logic [4:0] k, input string tag);
    exp_t e;
    @(posedge clk);
    op_code = op; src_a = a; src_b = b; imm16 = i; shamt = k;
    e = model(op, a, b, i, k);
    @(negedge clk);
    total++;
    if (result !== e.r || result_ok !== e.ok || ovf_trap !== e.tr) begin
      bad++;
      $display("FAIL %s op=%02h a=%08h b=%08h i=%04h k=%0d: got r=%08h ok=%b tr=%b exp r=%08h ok=%b tr=%b",
               tag, op, a, b, i, k, result, result_ok, ovf_trap, e.r, e.ok, e.tr);
    end
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hffff_ffff;
      3: return 32'h7fff_ffff;
      4: return 32'h8000_0000;
      default: return $urandom();
    endcase
  endfunction

  localparam logic [7:0] OPS [25] = '{
    8'h40, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45, 8'h4e, 8'h4f, 8'h50, 8'h51,
    8'h52, 8'h53, 8'h54, 8'h55, 8'h56, 8'h57, 8'h58, 8'h59, 8'h5a, 8'h5b,
    8'h5c, 8'h5d, 8'h5e, 8'ha2, 8'h46};

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state with all inputs zero: opcode 0 is unsupported (R12)
    apply(8'h00, 0, 0, 0, 0, "R12");
    // R1 wrap and R2 boundary
    apply(8'h40, 32'h7fff_fffe, 32'h1, 0, 0, "R1");
    apply(8'h40, 32'h7fff_ffff, 32'h1, 0, 0, "R2");
    apply(8'h40, 32'h8000_0000, 32'hffff_ffff, 0, 0, "R2");
    apply(8'h41, 32'h8000_0000, 0, 16'h8000, 0, "R2");
    apply(8'h41, 32'h0000_0005, 0, 16'hfffb, 0, "R1");
    apply(8'h42, 32'h7fff_ffff, 32'h1, 0, 0, "R4");
    apply(8'h43, 32'h7fff_ffff, 0, 16'h0001, 0, "R4");
    // R3 boundary
    apply(8'h44, 32'h8000_0000, 32'h1, 0, 0, "R3");
    apply(8'h44, 32'h7fff_ffff, 32'hffff_ffff, 0, 0, "R3");
    apply(8'h44, 32'hffff_ffff, 32'h7fff_ffff, 0, 0, "R3");
    apply(8'h45, 32'h8000_0000, 32'h1, 0, 0, "R4");
    // R6 zero extension
    apply(8'h4f, 32'hffff_ffff, 0, 16'h8001, 0, "R6");
    apply(8'h51, 32'h1234_0000, 0, 16'hf00f, 0, "R6");
    // R8 sign fill, R9 low five bits only
    apply(8'h59, 0, 32'h8000_0000, 0, 5'd31, "R8");
    apply(8'h5a, 32'hffff_ffe4, 32'h8000_00f0, 0, 5'd1, "R8");
    apply(8'h56, 32'h0000_0123, 32'h0000_0001, 0, 5'd7, "R9");
    apply(8'h58, 32'hdead_bee0, 32'h8000_0000, 0, 5'd9, "R9");
    apply(8'h57, 0, 32'h8000_0000, 0, 5'd4, "R7");
    // R10 signed vs unsigned with sign-extended immediate
    apply(8'h5e, 32'h0000_0010, 0, 16'hffff, 0, "R10");
    apply(8'h5c, 32'h0000_0010, 0, 16'hffff, 0, "R10");
    apply(8'h5b, 32'h8000_0000, 32'h1, 0, 0, "R10");
    apply(8'h5d, 32'h8000_0000, 32'h1, 0, 0, "R10");
    apply(8'ha2, 32'hffff_ffff, 32'hffff_ffff, 16'hbeef, 0, "R11");
    apply(8'h46, 32'h1, 32'h2, 16'h3, 5'd4, "R12");
    apply(8'hff, 32'h7fff_ffff, 32'h1, 0, 0, "R12");
    // constrained random sweep, trap ops tagged R13 alongside their own checks
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] op;
      op = OPS[$urandom_range(0, 24)];
      apply(op, pick(), pick(), 16'($urandom()), 5'($urandom()),
            (op inside {8'h40, 8'h41, 8'h44}) ? "R13" : tag_of(op));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule